// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block is the software-facing register file of a multi-channel event timer, together with the free-running main counter that all channels compare against. A host reaches it through a simple request bus. Each request is one 32-bit word, marked by a valid flag with a write flag, a byte address and write data. Every 64-bit quantity is reached as two words: the low half at the base offset and the high half at base + 4. Read data comes back one cycle after the request, together with a response flag.

The block keeps four things: a read-only capability word pair, a global configuration word, an interrupt status word and the 64-bit main counter. The counter advances by one on each `tick_stb` while the global enable is set. Clearing the enable stops the counter on its current value without zeroing it, and setting the enable again continues from that value. Per-channel registers sit in 32-byte windows that start at 0x100. The block does not hold them itself. It decodes the channel number and the word inside the window, then sends a one-hot read or write strobe, the word index, the data and a bit write mask to the channel logic, which returns its read word on a shared input. One-cycle arm and disarm strobes tell the channels when the global enable turns on or off.

Top module: `etmr_regs`

## Requirements
- R1: A synchronous active-low reset clears the main counter, the global configuration, the status bits and the read response (`rd_valid` = 0, `rd_data` = 0).
- R2: A read request in cycle t sets `rd_valid` and presents the data in cycle t+1. Offset 0x000 returns {VENDOR_ID[31:16], legacy-capable bit 15 = 1, bit 14 = 0, 64-bit-counter bit 13 = 1, NUM_TMR-1 in [12:8], REV_ID[7:0]}. Offset 0x004 returns TICK_FS, the tick period in femtoseconds. Writes to both offsets are ignored.
- R3: In the global configuration word at 0x010, only bit 0 (enable) and bit 1 (legacy route) can be written. All other bits read 0. The word at 0x014 reads 0 and ignores writes.
- R4: While enabled, the 64-bit counter (low word 0x0F0, high word 0x0F4) rises by exactly one per cycle with `tick_stb`, carrying from the low half into the high half. While disabled it holds its value, and after re-enabling it continues from the held value.
- R5: Either counter half can be written on its own, including while counting is enabled. A write in the same cycle as a tick takes the written value, and the other half is left as it was.
- R6: When the enable bit goes from 0 to 1, `arm_stb` is high for exactly one cycle, the first cycle in which `cnt_run` is 1. When it goes from 1 to 0, `disarm_stb` pulses in the same way. Writing the bit's current value pulses neither.
- R7: Status bit i at 0x020 is set by `tmr_evt[i]` only while enabled, and is cleared by writing 1 to it. A new event wins over a clear in the same cycle. Disabling clears all status bits. The word at 0x024 reads 0.
- R8: An aligned address A in 0x100..0x3FF selects channel (A-0x100)/32 and word ((A-0x100) mod 32)/4. Word 0 is config low, 1 is config high, 2 and 3 are the comparator, 4 and 5 are the route. The matching bit of `tmr_rd_stb` or `tmr_wr_stb` is high in the request cycle, and `tmr_rdata` is returned on `rd_data` in the next cycle.
- R9: A write to word 0 carries `tmr_wmask` = TCFG_WMASK. Writes to words 2 to 5 carry an all-ones mask. Writes to word 1 (read-only capability half) raise no write strobe.
- R10: A channel number at or above NUM_TMR, window words 6 and 7, unaligned addresses and undefined global offsets all read as 0 and raise no strobe.
- R11: `cnt_run` follows configuration bit 0 and `legacy_route` follows configuration bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response, one cycle after request |
| rd_data | output | 32 | Read data |
| tick_stb | input | 1 | Counter tick |
| tmr_evt | input | NUM_TMR | Per-channel event pulses into status |
| cnt_run | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy routing select |
| cnt_value | output | 64 | Main counter to the channels |
| arm_stb | output | 1 | Enable rose |
| disarm_stb | output | 1 | Enable fell |
| tmr_rd_stb | output | NUM_TMR | One-hot channel read strobe |
| tmr_wr_stb | output | NUM_TMR | One-hot channel write strobe |
| tmr_word | output | 3 | Word index inside the channel window |
| tmr_wdata | output | 32 | Channel write data |
| tmr_wmask | output | 32 | Channel write bit mask |
| tmr_rdata | input | 32 | Read word from the selected channel |

## Verification
The assertions check on every cycle that the counter stays frozen while disabled, that it steps by exactly one per enabled tick, that a low-half write lands, that the arm and disarm pulses never overlap and last one cycle, and that status bits are never gained while disabled and do drop when written with ones. They also check that channel strobes are at most one-hot and that the read-only config half never raises a write strobe. Only the bench scenarios show the rest. That covers the capability layout and the masked configuration read-back, and it covers resuming from a held count across a low-to-high carry. It also covers a write winning over a tick, an event winning over a clear, the decoding of out-of-range windows to zero, and the clearing of status on disable.

// File: rtl/etmr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the event timer register front end.
// Assumes a 1 KiB register space reached with aligned 32-bit words.
package etmr_pkg;
    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 5;
    localparam int WORD_W    = 3;
    localparam int TMR_WORDS = 6;
    localparam int CNT_W     = 64;

    localparam logic [ADDR_W-1:0] A_CAP_LO   = 10'h000;
    localparam logic [ADDR_W-1:0] A_CAP_HI   = 10'h004;
    localparam logic [ADDR_W-1:0] A_GCFG     = 10'h010;
    localparam logic [ADDR_W-1:0] A_STS      = 10'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO   = 10'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI   = 10'h0F4;
    localparam logic [ADDR_W-1:0] A_TMR_BASE = 10'h100;

    localparam logic [WORD_W-1:0] W_CFG_LO = 3'd0;
    localparam logic [WORD_W-1:0] W_CFG_HI = 3'd1;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CAP_LO,
        RG_CAP_HI,
        RG_GCFG,
        RG_STS,
        RG_CNT_LO,
        RG_CNT_HI,
        RG_TMR
    } region_e;
endpackage

// File: rtl/etmr_decode.sv
`timescale 1ns/1ps
// Address classifier: maps a byte address to a global register or to a
// channel window (channel number plus word index). Assumes 32-byte windows
// from A_TMR_BASE; unaligned, undefined or out-of-range addresses give RG_NONE.
module etmr_decode
    import etmr_pkg::*;
#(
    parameter int NUM_TMR = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  tmr_idx,
    output logic [WORD_W-1:0] tmr_word
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [IDX_W:0] NT_L = 6'(NUM_TMR);

    logic [WA_W-1:0] woff;

    // Classify the address into one register region.
    always_comb begin : p_decode
        woff     = addr[ADDR_W-1:2] - A_TMR_BASE[ADDR_W-1:2];
        tmr_idx  = woff[WA_W-1 -: IDX_W];
        tmr_word = woff[WORD_W-1:0];
        region   = RG_NONE;
        if (addr[1:0] != 2'b00) begin
            region = RG_NONE;
        end else if (addr >= A_TMR_BASE) begin
            if (({1'b0, tmr_idx} < NT_L) && (tmr_word < 3'(TMR_WORDS)))
                region = RG_TMR;
        end else begin
            case (addr)
                A_CAP_LO: region = RG_CAP_LO;
                A_CAP_HI: region = RG_CAP_HI;
                A_GCFG:   region = RG_GCFG;
                A_STS:    region = RG_STS;
                A_CNT_LO: region = RG_CNT_LO;
                A_CNT_HI: region = RG_CNT_HI;
                default:  region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/etmr_counter.sv
`timescale 1ns/1ps
// Main up-counter. It advances once per tick while run is set, holds its
// value otherwise, and accepts writes of either half at any time. A write
// takes priority over a tick in the same cycle.
module etmr_counter #(
    parameter int CNT_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 tick,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [CNT_W/2-1:0]   wdata,
    output logic [CNT_W-1:0]     cnt
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Count state: reset, half writes, then enabled ticks.
    always_ff @(posedge clk) begin : p_count
        if (!rst_n)           cnt <= '0;
        else if (wr_lo)       cnt[HALF-1:0] <= wdata;
        else if (wr_hi)       cnt[CNT_W-1:HALF] <= wdata;
        else if (run && tick) cnt <= cnt + ONE;
    end

    // R4: disabled and unwritten means frozen
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));

    // R4: one enabled tick adds exactly one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + ONE));

    // R5: a low-half write lands even when a tick coincides
    p_wr_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt[HALF-1:0] == $past(wdata)));
endmodule

// File: rtl/etmr_ctrl.sv
`timescale 1ns/1ps
// Global configuration and interrupt status. Holds the masked configuration
// word, makes one-cycle arm/disarm pulses on enable edges and keeps
// write-one-to-clear status bits that are set by channel events while enabled.
module etmr_ctrl #(
    parameter int          NUM_TMR    = 3,
    parameter logic [31:0] GCFG_WMASK = 32'h0000_0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_gcfg,
    input  logic               wr_sts,
    input  logic [31:0]        wdata,
    input  logic [NUM_TMR-1:0] tmr_evt,
    output logic [31:0]        gcfg,
    output logic [NUM_TMR-1:0] sts,
    output logic               arm_stb,
    output logic               disarm_stb
);
    logic run;
    logic going_on;
    logic going_off;
    logic [NUM_TMR-1:0] clr_bits;
    logic [NUM_TMR-1:0] set_bits;

    assign run       = gcfg[0];
    assign going_on  = wr_gcfg && wdata[0] && !gcfg[0];
    assign going_off = wr_gcfg && !wdata[0] && gcfg[0];
    assign clr_bits  = wr_sts ? wdata[NUM_TMR-1:0] : '0;
    assign set_bits  = run ? tmr_evt : '0;

    // Configuration word: only masked bits change.
    always_ff @(posedge clk) begin : p_gcfg
        if (!rst_n)       gcfg <= '0;
        else if (wr_gcfg) gcfg <= (wdata & GCFG_WMASK) | (gcfg & ~GCFG_WMASK);
    end

    // Enable edge pulses, aligned with the first cycle of the new state.
    always_ff @(posedge clk) begin : p_edges
        if (!rst_n) begin
            arm_stb    <= 1'b0;
            disarm_stb <= 1'b0;
        end else begin
            arm_stb    <= going_on;
            disarm_stb <= going_off;
        end
    end

    // Status: disable clears, events beat write-one-to-clear.
    always_ff @(posedge clk) begin : p_status
        if (!rst_n)         sts <= '0;
        else if (going_off) sts <= '0;
        else                sts <= (sts & ~clr_bits) | set_bits;
    end

    // R3: the configuration only changes on a write
    p_gcfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gcfg |=> $stable(gcfg));

    // R6: arm and disarm never together
    p_edge_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arm_stb, disarm_stb}));

    // R6: an arm pulse lasts a single cycle
    p_arm_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm_stb |=> !arm_stb);

    // R7: no status bit appears while disabled
    p_no_set_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((sts & ~$past(sts)) == '0));

    // R7: written ones clear when no event competes
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && (tmr_evt == '0)) |=> ((sts & $past(wdata[NUM_TMR-1:0])) == '0));
endmodule

// File: rtl/etmr_regs.sv
`timescale 1ns/1ps
// Event timer register front end (top). Decodes word accesses, holds the
// capability, configuration, status and main counter, and forwards channel
// window accesses as one-hot strobes. Read data is registered: a request in
// cycle t answers in cycle t+1. Assumes 3 <= NUM_TMR <= 24 (window space).
module etmr_regs
    import etmr_pkg::*;
#(
    parameter int          NUM_TMR    = 3,
    parameter logic [31:0] TICK_FS    = 32'd10_000_000,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
    parameter logic [31:0] TCFG_WMASK = 32'h0000_7F4E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [9:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    input  logic               tick_stb,
    input  logic [NUM_TMR-1:0] tmr_evt,
    output logic               cnt_run,
    output logic               legacy_route,
    output logic [63:0]        cnt_value,
    output logic               arm_stb,
    output logic               disarm_stb,
    output logic [NUM_TMR-1:0] tmr_rd_stb,
    output logic [NUM_TMR-1:0] tmr_wr_stb,
    output logic [2:0]         tmr_word,
    output logic [31:0]        tmr_wdata,
    output logic [31:0]        tmr_wmask,
    input  logic [31:0]        tmr_rdata
);
    localparam logic [4:0]  NT_M1  = 5'(NUM_TMR - 1);
    localparam logic [31:0] CAP_LO = {VENDOR_ID, 1'b1, 1'b0, 1'b1, NT_M1, REV_ID};

    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;
    logic              rd_req;
    logic              wr_req;
    logic [31:0]       gcfg;
    logic [NUM_TMR-1:0] sts;
    logic [31:0]       rd_next;

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;

    etmr_decode #(.NUM_TMR(NUM_TMR)) u_decode (
        .addr     (bus_addr),
        .region   (region),
        .tmr_idx  (idx),
        .tmr_word (word)
    );

    etmr_ctrl #(.NUM_TMR(NUM_TMR), .GCFG_WMASK(32'h0000_0003)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_gcfg    (wr_req && (region == RG_GCFG)),
        .wr_sts     (wr_req && (region == RG_STS)),
        .wdata      (bus_wdata),
        .tmr_evt    (tmr_evt),
        .gcfg       (gcfg),
        .sts        (sts),
        .arm_stb    (arm_stb),
        .disarm_stb (disarm_stb)
    );

    etmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gcfg[0]),
        .tick  (tick_stb),
        .wr_lo (wr_req && (region == RG_CNT_LO)),
        .wr_hi (wr_req && (region == RG_CNT_HI)),
        .wdata (bus_wdata),
        .cnt   (cnt_value)
    );

    assign cnt_run      = gcfg[0];
    assign legacy_route = gcfg[1];
    assign tmr_word     = word;
    assign tmr_wdata    = bus_wdata;
    assign tmr_wmask    = (word == W_CFG_LO) ? TCFG_WMASK : '1;

    // One strobe pair per implemented channel.
    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_stb
        assign tmr_rd_stb[gi] = rd_req && (region == RG_TMR) && (idx == 5'(gi));
        assign tmr_wr_stb[gi] = wr_req && (region == RG_TMR) && (idx == 5'(gi))
                                && (word != W_CFG_HI);
    end

    // Select the read word for the addressed register.
    always_comb begin : p_rd_mux
        case (region)
            RG_CAP_LO: rd_next = CAP_LO;
            RG_CAP_HI: rd_next = TICK_FS;
            RG_GCFG:   rd_next = gcfg;
            RG_STS:    rd_next = 32'(sts);
            RG_CNT_LO: rd_next = cnt_value[31:0];
            RG_CNT_HI: rd_next = cnt_value[63:32];
            RG_TMR:    rd_next = tmr_rdata;
            default:   rd_next = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin : p_rd_resp
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? rd_next : '0;
        end
    end

    // R2: every read request is answered next cycle
    p_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R8: at most one channel strobed at a time
    p_stb_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_rd_stb | tmr_wr_stb));

    // R9: the read-only config half never sees a write strobe
    p_cfg_hi_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_word == W_CFG_HI) |-> (tmr_wr_stb == '0));

    // R10: no strobe without a request
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> ((tmr_rd_stb | tmr_wr_stb) == '0));
endmodule

// File: tb/etmr_regs_tb.sv
`timescale 1ns/1ps
module etmr_regs_tb;
    localparam int          NT    = 4;
    localparam logic [31:0] WMASK = 32'h0000_7F4E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic tick_stb = 1'b0;
    logic [NT-1:0] tmr_evt = '0;
    logic cnt_run, legacy_route, arm_stb, disarm_stb;
    logic [63:0] cnt_value;
    logic [NT-1:0] tmr_rd_stb, tmr_wr_stb;
    logic [2:0] tmr_word;
    logic [31:0] tmr_wdata, tmr_wmask, tmr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NT-1:0] cap_rd_stb, cap_wr_stb;
    logic [2:0]    cap_word;
    logic [31:0]   cap_mask, cap_wdata;

    always #2 clk = ~clk;

    etmr_regs #(.NUM_TMR(NT), .TCFG_WMASK(WMASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .tick_stb(tick_stb), .tmr_evt(tmr_evt),
        .cnt_run(cnt_run), .legacy_route(legacy_route), .cnt_value(cnt_value),
        .arm_stb(arm_stb), .disarm_stb(disarm_stb), .tmr_rd_stb(tmr_rd_stb),
        .tmr_wr_stb(tmr_wr_stb), .tmr_word(tmr_word), .tmr_wdata(tmr_wdata),
        .tmr_wmask(tmr_wmask), .tmr_rdata(tmr_rdata)
    );

    // Channel model: answers {A5, channel, 0, word} for the strobed channel.
    always_comb begin
        tmr_rdata = '0;
        for (int i = 0; i < NT; i++)
            if (tmr_rd_stb[i]) tmr_rdata = {8'hA5, 8'(i), 13'h0, tmr_word};
    end

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 10'h000, 32'h1D0F_A301, 4'd2},  // R2 capability layout
        '{1'b0, 10'h004, 32'h0098_9680, 4'd2},  // R2 tick period
        '{1'b1, 10'h000, 32'hFFFF_FFFF, 4'd2},
        '{1'b0, 10'h000, 32'h1D0F_A301, 4'd2},  // R2 write ignored
        '{1'b1, 10'h010, 32'hFFFF_FFFC, 4'd3},
        '{1'b0, 10'h010, 32'h0000_0000, 4'd3},  // R3 masked bits
        '{1'b1, 10'h014, 32'hFFFF_FFFF, 4'd3},
        '{1'b0, 10'h014, 32'h0000_0000, 4'd3},  // R3 upper word
        '{1'b1, 10'h0F0, 32'h1234_5678, 4'd5},
        '{1'b1, 10'h0F4, 32'h0000_ABCD, 4'd5},
        '{1'b0, 10'h0F0, 32'h1234_5678, 4'd5},  // R5 low half
        '{1'b0, 10'h0F4, 32'h0000_ABCD, 4'd5},  // R5 high half
        '{1'b0, 10'h120, 32'hA501_0000, 4'd8},  // R8 ch1 word0
        '{1'b0, 10'h16C, 32'hA503_0003, 4'd8},  // R8 ch3 word3
        '{1'b0, 10'h180, 32'h0000_0000, 4'd10}, // R10 ch4 absent
        '{1'b0, 10'h118, 32'h0000_0000, 4'd10}, // R10 word6
        '{1'b0, 10'h122, 32'h0000_0000, 4'd10}, // R10 unaligned
        '{1'b0, 10'h030, 32'h0000_0000, 4'd10}, // R10 undefined global
        '{1'b0, 10'h024, 32'h0000_0000, 4'd7}   // R7 status upper word
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        cap_wr_stb = tmr_wr_stb; cap_word = tmr_word;
        cap_mask = tmr_wmask; cap_wdata = tmr_wdata;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        cap_rd_stb = tmr_rd_stb;
        @(negedge clk);
        bus_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse_tick(input int n);
        @(negedge clk);
        tick_stb = 1'b1;
        repeat (n) @(negedge clk);
        tick_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 rd_data", 64'(rd_data), 64'd0);
        chk("R1 counter", cnt_value, 64'd0);
        chk("R1 run", 64'(cnt_run), 64'd0);
        bus_rd(10'h010, d); chk("R1 gcfg", 64'(d), 64'd0);
        bus_rd(10'h020, d); chk("R1 status", 64'(d), 64'd0);
        chk("R2 rd_valid after read", 64'(rd_valid), 64'd1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].wr) bus_wr(VEC[v].addr, VEC[v].data);
            else begin
                bus_rd(VEC[v].addr, d);
                checks++;
                if (d !== VEC[v].data) begin
                    errors++;
                    $display("FAIL R%0d row %0d addr=%h actual=%h expected=%h",
                             VEC[v].req, v, VEC[v].addr, d, VEC[v].data);
                end
            end
        end

        // R8 read strobe on channel 1
        bus_rd(10'h120, d);
        chk("R8 rd strobe", 64'(cap_rd_stb), 64'(4'b0010));
        // R9 config low write carries the mask
        bus_wr(10'h140, 32'hDEAD_BEEF);
        chk("R9 wr strobe ch2", 64'(cap_wr_stb), 64'(4'b0100));
        chk("R9 word0", 64'(cap_word), 64'd0);
        chk("R9 mask word0", 64'(cap_mask), 64'(WMASK));
        chk("R8 wdata", 64'(cap_wdata), 64'h0000_0000_DEAD_BEEF);
        bus_wr(10'h144, 32'h1111_1111);
        chk("R9 cfg-high write dropped", 64'(cap_wr_stb), 64'd0);
        bus_wr(10'h148, 32'h2222_2222);
        chk("R9 comparator strobe", 64'(cap_wr_stb), 64'(4'b0100));
        chk("R9 comparator mask", 64'(cap_mask), 64'hFFFF_FFFF);
        bus_wr(10'h180, 32'h3333_3333);
        chk("R10 absent channel write", 64'(cap_wr_stb), 64'd0);
        bus_wr(10'h11C, 32'h4444_4444);
        chk("R10 word7 write", 64'(cap_wr_stb), 64'd0);

        // R4 freeze, resume and carry
        bus_wr(10'h0F0, 32'hFFFF_FFFE);
        bus_wr(10'h0F4, 32'h0000_0000);
        pulse_tick(5);
        bus_rd(10'h0F0, d); chk("R4 frozen while disabled", 64'(d), 64'hFFFF_FFFE);
        bus_wr(10'h010, 32'h1);
        chk("R6 arm pulse", 64'(arm_stb), 64'd1);
        chk("R11 run", 64'(cnt_run), 64'd1);
        @(negedge clk);
        chk("R6 arm one cycle", 64'(arm_stb), 64'd0);
        pulse_tick(3);
        bus_rd(10'h0F0, d); chk("R4 low after carry", 64'(d), 64'd1);
        bus_rd(10'h0F4, d); chk("R4 high after carry", 64'(d), 64'd1);
        bus_wr(10'h010, 32'h0);
        chk("R6 disarm pulse", 64'(disarm_stb), 64'd1);
        pulse_tick(4);
        bus_rd(10'h0F0, d); chk("R4 held value", 64'(d), 64'd1);
        bus_wr(10'h010, 32'h1);
        pulse_tick(2);
        bus_rd(10'h0F0, d); chk("R4 resumed", 64'(d), 64'd3);

        // R5 write beats a tick in the same cycle
        @(negedge clk);
        tick_stb = 1'b1; bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 10'h0F0; bus_wdata = 32'h0000_0100;
        @(negedge clk);
        tick_stb = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_rd(10'h0F0, d); chk("R5 write wins over tick", 64'(d), 64'h100);
        bus_rd(10'h0F4, d); chk("R5 other half kept", 64'(d), 64'd1);

        // R11 legacy route, R6 no pulse on unchanged enable
        bus_wr(10'h010, 32'h3);
        chk("R11 legacy", 64'(legacy_route), 64'd1);
        chk("R6 no re-arm", 64'(arm_stb), 64'd0);
        bus_rd(10'h010, d); chk("R3 gcfg readback", 64'(d), 64'd3);

        // R7 status behaviour
        @(negedge clk); tmr_evt = 4'b1010;
        @(negedge clk); tmr_evt = '0;
        bus_rd(10'h020, d); chk("R7 events set", 64'(d), 64'hA);
        bus_wr(10'h020, 32'h2);
        bus_rd(10'h020, d); chk("R7 write one clears", 64'(d), 64'h8);
        @(negedge clk);
        tmr_evt = 4'b1000; bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 10'h020; bus_wdata = 32'h8;
        @(negedge clk);
        tmr_evt = '0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_rd(10'h020, d); chk("R7 event beats clear", 64'(d), 64'h8);
        bus_wr(10'h010, 32'h0);
        bus_rd(10'h020, d); chk("R7 disable clears", 64'(d), 64'h0);
        @(negedge clk); tmr_evt = 4'b0001;
        @(negedge clk); tmr_evt = '0;
        bus_rd(10'h020, d); chk("R7 no set while disabled", 64'(d), 64'h0);

        // R1 reset mid-run
        bus_wr(10'h010, 32'h3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 counter after reset", cnt_value, 64'd0);
        chk("R1 legacy after reset", 64'(legacy_route), 64'd0);

        finish_run();
    end
endmodule